// File: doc/BRIEF.md
# Pipelined Look-Ahead Binary Counter

This block is a wide binary up-counter built so that its clock period stays the same however wide it is. The count is split into short counting slices. The lowest slice is narrow and each slice above it is wider. Every slice is clocked on the same edge. A slice above the lowest one advances only when it receives a carry. That carry is not rippled through the lower slices in the same cycle. A separate look-ahead path works it out one cycle before the wrap and keeps it in a register. In the cycle of the wrap, the carry is then just that register ANDed with the count enable.

The caller drives a count enable. It reads `count_o` as a plain binary value on every cycle. No decode step is needed and there is no pipeline latency: after any enabled edge, the output already holds the new total. The total width and the slice widths are parameters.

Top module: `lookahead_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` reads 0 and every look-ahead flag is cleared. The first enabled edge after reset is released yields a count of 1.
- R2: On each rising edge with `en_i` high, `count_o` becomes its previous value plus one, visible in the cycle right after that edge.
- R3: On a rising edge with `en_i` low, `count_o` keeps its value.
- R4: An enabled edge at all-ones (0xFFFF at the default width) makes the count 0.
- R5: Slice 0 covers bits [LSB_W-1:0]. Slice k ≥ 1 starts at bit LSB_W+(k-1)·SEG_W, so the defaults give boundaries at bits 2, 6, 10 and 14. A slice k ≥ 1 changes only on an enabled edge at which every bit below it is 1. The carry comes from a registered look-ahead flag that, when set, exactly means "all lower bits are ones".
- R6: If the enable drops while the lower slices are all ones, the pending carry is held without effect for as long as the enable stays low. It is applied exactly once on the next enabled edge. At the default width, 0x03FF held for several cycles and then enabled once gives 0x0400.
- R7: At every cycle, `count_o` equals the number of enabled edges since reset, modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all state on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable |
| count_o | output | WIDTH | Binary count |

## Verification
Every result of this block is due one rising edge after its stimulus. The enable is applied at a falling edge. The counter acts on it at the next rising edge. The new value is checked at the following falling edge against an integer reference that adds one per enabled edge. This single-edge spacing also covers carries across the slice boundaries and the full wrap, because the look-ahead register is expected to have prepared the carry one cycle earlier. Reset is the only asynchronous result: it is checked shortly after `rst_ni` falls, with no clock edge in between.

// File: rtl/lac_pkg.sv
package lac_pkg;
  function automatic int seg_count(int w, int lw, int sw);
    return 1 + (w - lw + sw - 1) / sw;
  endfunction

  function automatic int seg_lo(int k, int lw, int sw);
    return (k == 0) ? 0 : lw + (k - 1) * sw;
  endfunction

  function automatic int seg_width(int k, int w, int lw, int sw);
    int lo;
    int wd;
    lo = seg_lo(k, lw, sw);
    wd = (k == 0) ? lw : sw;
    if (lo + wd > w) wd = w - lo;
    return wd;
  endfunction
endpackage

// File: rtl/lac_segment.sv
module lac_segment #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (step_i) val_q <= val_q + 1'b1;
  end

  assign val_o = val_q;

  // R5: a slice without its carry must not move
  p_seg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(step_i) |-> $stable(val_o));
endmodule

// File: rtl/lac_lookahead.sv
module lac_lookahead #(
  parameter int NSEG  = 5,
  parameter int LSB_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LSB_W-1:0] low_val_i,
  input  logic [NSEG-1:1]  seg_ones_i,
  output logic [NSEG-1:1]  carry_o
);
  localparam logic [LSB_W-1:0] LowNear = {{(LSB_W-1){1'b1}}, 1'b0};

  logic             low_near;
  logic             low_ones;
  logic [NSEG-1:1]  mid_ones;
  logic [NSEG-1:1]  flag_q;

  assign low_near = (low_val_i == LowNear);
  assign low_ones = &low_val_i;

  // slices above 0 are frozen on the edge where slice 0 is one short of full
  assign mid_ones[1] = 1'b1;
  for (genvar k = 2; k < NSEG; k++) begin : g_mid
    assign mid_ones[k] = mid_ones[k-1] & seg_ones_i[k-1];
  end

  for (genvar k = 1; k < NSEG; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   flag_q[k] <= 1'b0;
      else if (en_i) flag_q[k] <= low_near & mid_ones[k];
    end

    assign carry_o[k] = en_i & flag_q[k];

    // R5: registered early flag agrees with the live lower bits
    p_flag_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[k] == (low_ones & mid_ones[k]));
  end
endmodule

// File: rtl/lookahead_counter.sv
module lookahead_counter #(
  parameter int WIDTH = 16,
  parameter int LSB_W = 2,
  parameter int SEG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o
);
  import lac_pkg::*;

  localparam int NSEG = seg_count(WIDTH, LSB_W, SEG_W);

  wire [WIDTH-1:0] cnt;
  wire [NSEG-1:1]  seg_ones;
  wire [NSEG-1:1]  carry;

  lac_segment #(.W(LSB_W)) i_seg0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (en_i),
    .val_o  (cnt[LSB_W-1:0])
  );

  for (genvar k = 1; k < NSEG; k++) begin : g_seg
    localparam int Lo = seg_lo(k, LSB_W, SEG_W);
    localparam int Sw = seg_width(k, WIDTH, LSB_W, SEG_W);

    lac_segment #(.W(Sw)) i_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (carry[k]),
      .val_o  (cnt[Lo +: Sw])
    );

    assign seg_ones[k] = &cnt[Lo +: Sw];
  end

  lac_lookahead #(.NSEG(NSEG), .LSB_W(LSB_W)) i_look (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .low_val_i  (cnt[LSB_W-1:0]),
    .seg_ones_i (seg_ones),
    .carry_o    (carry)
  );

  assign count_o = cnt;

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(en_i) |-> count_o == WIDTH'($past(count_o) + 1'b1));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(en_i) |-> $stable(count_o));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(en_i) && ($past(count_o) == '1) |-> count_o == '0);
endmodule

// File: tb/test_lookahead_counter.sv
`timescale 1ns/1ps
module test_lookahead_counter;
  localparam int WIDTH = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  wire [WIDTH-1:0] count_o;

  int errors = 0;
  int checks = 0;
  logic [WIDTH-1:0] exp_cnt = '0;
  int unsigned edges = 0;

  lookahead_counter #(.WIDTH(WIDTH)) i_lookahead_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .count_o (count_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(string tag, logic [WIDTH-1:0] e);
    checks++;
    if (count_o !== e) begin
      errors++;
      $display("FAIL %s: count=%h expected=%h", tag, count_o, e);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(bit e, string tag = "");
    logic [WIDTH-1:0] prev;
    string t;
    en_i = e;
    @(negedge clk_i);
    prev = exp_cnt;
    if (e) begin
      exp_cnt = exp_cnt + 1'b1;
      edges++;
    end
    if (tag != "")                     t = tag;
    else if (!e)                       t = "R3";
    else if (exp_cnt == '0)            t = "R4";
    else if (((prev ^ exp_cnt) >> 2) != 0) t = "R5";
    else                               t = "R2";
    chk(t, exp_cnt);
  endtask

  task automatic total_check();
    checks++;
    if (count_o !== WIDTH'(edges)) begin
      errors++;
      $display("FAIL R7: count=%h expected=%h", count_o, WIDTH'(edges));
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: count=%h expected=finish", count_o);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", '0);
    rst_ni = 1'b1;
    step(1'b1, "R1");

    repeat (3000) step(1'($urandom_range(0, 1)));
    total_check();

    // pending carry into bit 10 held across idle cycles
    while (exp_cnt != 16'h03FF) step(1'b1);
    repeat (4) step(1'b0, "R6");
    step(1'b1, "R6");
    step(1'b0, "R6");

    // long run through every slice boundary and the full wrap
    do step(1'b1); while (exp_cnt != '0);
    total_check();

    for (int i = 0; i < 4000; i++) step(i % 3 != 0);
    total_check();

    // asynchronous reset mid-count
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    exp_cnt = '0;
    edges = 0;
    chk("R1", '0);
    @(negedge clk_i);
    chk("R1", '0);
    rst_ni = 1'b1;
    step(1'b1, "R1");
    total_check();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule